// File: doc/BRIEF.md
# Multiplexed Analog Readout Sequencer

This block runs the readout of a bank of track-and-hold front-end channels that share one analog output line. A trigger seen while idle makes it assert a hold line to freeze every channel. After one settling slot it steps a slow readout clock, derived from the fast sample clock by a divider with equal high and low times. Each rising edge of that clock puts the next channel on the shared line.

A fast 12-bit ADC samples the shared line on every sample clock. The block oversamples each channel slot but keeps only the last few samples of the slot, after the line has settled. It adds them in a widened accumulator and divides by their count with a shift, which truncates. The result is written into a buffer addressed by channel number.

When the last channel has been written, the block releases hold, sends one clear pulse to the front end and raises a one-cycle done pulse. A downstream formatter then fetches the values through a registered read port. With the defaults there are 64 channels, ten sample periods per slot and four averaged samples. A readout takes 651 sample clocks from the trigger edge to the done pulse.

Top module: `mux_rdout_seq`

## Requirements
- R1: While reset is applied, and on leaving reset, fe_hold_o, fe_clk_o, fe_clr_o, busy_o and done_o are all low. An asynchronous assertion of rst_n forces these outputs low at once, even in the middle of a readout, and no readout is left pending.
- R2: trig_i is sampled at a rising clock edge. If it is high while the block is idle, fe_hold_o and busy_o go high in the next cycle. For DIV cycles (one settling slot) fe_clk_o stays low, and the first rising edge of fe_clk_o comes DIV cycles after hold rose.
- R3: During readout fe_clk_o has period DIV cycles: high for DIV/2 cycles, then low for the rest. It is only ever high while fe_hold_o is high. Each readout makes exactly NCH rising edges.
- R4: Slot k (k = 0..NCH-1) is the DIV cycles that start with the (k+1)-th rising edge of fe_clk_o. Its buffer entry is the sum of the ADC samples in the last NAVG cycles of the slot, shifted right by log2(NAVG), so the result is truncated. Full-scale input (4095 in every cycle) gives exactly 4095, with no overflow.
- R5: ADC samples in the first DIV-NAVG cycles of a slot and in the settling slot have no effect on any buffer entry.
- R6: A trigger that arrives while busy_o is high is ignored. The readout in progress keeps its timing, and no second readout follows it.
- R7: In the cycle after the last slot, fe_hold_o is low and fe_clr_o and done_o are both high for exactly one cycle. With the defaults this is the 651st cycle after the trigger edge.
- R8: busy_o stays high from the cycle after an accepted trigger through the done cycle, and is low in the cycle after it.
- R9: rd_data_o shows the buffer entry at rd_addr_i one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, also clocks the ADC |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_i | input | 1 | Readout start request |
| adc_i | input | 12 | ADC sample of the shared analog line |
| rd_addr_i | input | 6 | Buffer read address (channel number) |
| fe_hold_o | output | 1 | Track-and-hold freeze to the front end |
| fe_clk_o | output | 1 | Multiplexer readout clock to the front end |
| fe_clr_o | output | 1 | One-cycle front-end clear pulse |
| busy_o | output | 1 | Readout in progress |
| done_o | output | 1 | One-cycle pulse: buffer complete |
| rd_data_o | output | 12 | Averaged value of the addressed channel |

## Verification
Several ADC patterns are driven in a cycle-exact way against the derived slot timing, and after each run all 64 entries are read back:
- Full scale in every cycle tells a correct 14-bit sum apart from a truncated accumulator.
- A per-channel ramp whose settling samples are full-scale garbage exposes a wrong sample window or a channel index off by one.
- All-zero averaging samples under full-scale early samples show that only the tail of each slot counts.
- A mixed hash pattern with nonzero low bits checks truncation.

The control outputs are compared in every cycle against the expected slot count, clock phase, hold window, clear and done timing. Extra triggers during a readout and a reset applied in the middle of a readout confirm that the sequence cannot be restarted or left half done.

// File: rtl/mux_rdout_pkg.sv
package mux_rdout_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_READ   = 2'd2,
    ST_CLEAR  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/mux_rdout_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module mux_rdout_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mux_rdout_ctrl.sv
// Sequencer: slot divider, channel counter, front-end control decode.
module mux_rdout_ctrl
  import mux_rdout_pkg::*;
#(
  parameter int NCH  = 64,
  parameter int DIV  = 10,
  parameter int NAVG = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig_i,
  output logic            fe_hold_o,
  output logic            fe_clk_o,
  output logic            fe_clr_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [CH_W-1:0] ch_o,
  output logic            smp_en_o,
  output logic            smp_first_o,
  output logic            wr_en_o
);
  localparam int PH_W = $clog2(DIV);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF  = PH_W'(DIV / 2);
  localparam logic [PH_W-1:0] PH_AVG0  = PH_W'(DIV - NAVG);
  localparam logic [CH_W-1:0] CH_LAST  = CH_W'(NCH - 1);

  seq_state_t      st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic            ph_en, ch_en;
  logic            ph_last, ch_last, in_read;

  assign ph_last = (ph_q == PH_LAST);
  assign ch_last = (ch_q == CH_LAST);
  assign in_read = (st_q == ST_READ);

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    ph_d  = ph_q;
    ch_d  = ch_q;
    ph_en = 1'b0;
    ch_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (trig_i) begin
          st_d  = ST_SETTLE;
          ph_d  = '0;
          ph_en = 1'b1;
        end
      end
      ST_SETTLE: begin
        ph_en = 1'b1;
        if (ph_last) begin
          ph_d  = '0;
          st_d  = ST_READ;
          ch_d  = '0;
          ch_en = 1'b1;
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      ST_READ: begin
        ph_en = 1'b1;
        if (ph_last) begin
          ph_d  = '0;
          ch_en = 1'b1;
          if (ch_last) begin
            st_d = ST_CLEAR;
            ch_d = '0;
          end else begin
            ch_d = ch_q + CH_W'(1);
          end
        end else begin
          ph_d = ph_q + PH_W'(1);
        end
      end
      ST_CLEAR: st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= '0;
    else if (ph_en) ph_q <= ph_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ch_q <= '0;
    else if (ch_en) ch_q <= ch_d;
  end

  // Output decode
  assign fe_hold_o   = (st_q == ST_SETTLE) || in_read;
  assign fe_clk_o    = in_read && (ph_q < PH_HALF);
  assign fe_clr_o    = (st_q == ST_CLEAR);
  assign done_o      = (st_q == ST_CLEAR);
  assign busy_o      = (st_q != ST_IDLE);
  assign ch_o        = ch_q;
  assign smp_en_o    = in_read && (ph_q >= PH_AVG0);
  assign smp_first_o = in_read && (ph_q == PH_AVG0);
  assign wr_en_o     = in_read && ph_last;
endmodule

// File: rtl/mux_rdout_avg.sv
// Accumulates the settled tail of a slot and divides by a shift.
module mux_rdout_avg #(
  parameter int W    = 12,
  parameter int NAVG = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en_i,
  input  logic         smp_first_i,
  input  logic [W-1:0] adc_i,
  output logic [W-1:0] avg_o
);
  localparam int SH    = $clog2(NAVG);
  localparam int SUM_W = W + SH;

  logic [SUM_W-1:0] acc_q, sum_now;

  assign sum_now = (smp_first_i ? '0 : acc_q) + SUM_W'(adc_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc_q <= '0;
    else if (smp_en_i) acc_q <= sum_now;
  end

  assign avg_o = sum_now[SUM_W-1:SH];
endmodule

// File: rtl/mux_rdout_buf.sv
// Channel-indexed result store with a registered read port.
module mux_rdout_buf #(
  parameter int DEPTH = 64,
  parameter int W     = 12,
  parameter int A_W   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we_i,
  input  logic [A_W-1:0] wa_i,
  input  logic [W-1:0]   wd_i,
  input  logic [A_W-1:0] ra_i,
  output logic [W-1:0]   rd_o
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[wa_i] <= wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_o <= '0;
    else        rd_o <= mem[ra_i];
  end
endmodule

// File: rtl/mux_rdout_seq.sv
module mux_rdout_seq #(
  parameter int NCH   = 64,
  parameter int DIV   = 10,
  parameter int NAVG  = 4,
  parameter int ADC_W = 12,
  parameter int CH_W  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [ADC_W-1:0] adc_i,
  input  logic [CH_W-1:0]  rd_addr_i,
  output logic             fe_hold_o,
  output logic             fe_clk_o,
  output logic             fe_clr_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [ADC_W-1:0] rd_data_o
);
  logic             rst_sync_n;
  logic [CH_W-1:0]  ch;
  logic             smp_en, smp_first, wr_en;
  logic [ADC_W-1:0] avg;

  mux_rdout_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  mux_rdout_ctrl #(.NCH(NCH), .DIV(DIV), .NAVG(NAVG), .CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .trig_i(trig_i),
    .fe_hold_o(fe_hold_o), .fe_clk_o(fe_clk_o), .fe_clr_o(fe_clr_o),
    .busy_o(busy_o), .done_o(done_o), .ch_o(ch),
    .smp_en_o(smp_en), .smp_first_o(smp_first), .wr_en_o(wr_en)
  );

  mux_rdout_avg #(.W(ADC_W), .NAVG(NAVG)) u_avg (
    .clk(clk), .rst_n(rst_sync_n), .smp_en_i(smp_en),
    .smp_first_i(smp_first), .adc_i(adc_i), .avg_o(avg)
  );

  mux_rdout_buf #(.DEPTH(NCH), .W(ADC_W), .A_W(CH_W)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .we_i(wr_en), .wa_i(ch),
    .wd_i(avg), .ra_i(rd_addr_i), .rd_o(rd_data_o)
  );
endmodule

// File: rtl/mux_rdout_chk.sv
module mux_rdout_chk #(
  parameter int DIV = 10
) (
  input logic clk,
  input logic rst_n,
  input logic trig,
  input logic busy,
  input logic done,
  input logic fe_hold,
  input logic fe_clk,
  input logic fe_clr
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hi_cnt <= '0;
    else if (fe_clk) hi_cnt <= hi_cnt + 8'd1;
    else             hi_cnt <= '0;
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_clr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fe_clr && !fe_hold));
  a_r8_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  a_r3_clk_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fe_clk |-> fe_hold);
  a_r3_clk_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    fe_clk |-> (hi_cnt < 8'(DIV / 2)));
  a_r2_hold_from_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_hold) |-> $past(trig && !busy));
  a_r6_trig_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && trig) |=> busy);
endmodule

bind mux_rdout_seq mux_rdout_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig(trig_i), .busy(busy_o), .done(done_o),
  .fe_hold(fe_hold_o), .fe_clk(fe_clk_o), .fe_clr(fe_clr_o)
);

// File: tb/tb_mux_rdout_seq.sv
module tb_mux_rdout_seq;
  localparam int NCH  = 64;
  localparam int DIV  = 10;
  localparam int NAVG = 4;
  localparam int TOTAL = DIV + NCH * DIV + 1;

  logic        clk;
  logic        rst_n;
  logic        trig;
  logic [11:0] adc;
  logic [5:0]  rd_addr;
  logic        fe_hold, fe_clk, fe_clr, busy, done;
  logic [11:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int expv [NCH];

  mux_rdout_seq dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .adc_i(adc),
    .rd_addr_i(rd_addr), .fe_hold_o(fe_hold), .fe_clk_o(fe_clk),
    .fe_clr_o(fe_clr), .busy_o(busy), .done_o(done), .rd_data_o(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pat(input int pass, input int ch, input int ph);
    case (pass)
      0: return 4095;
      1: return (ph < DIV - NAVG) ? 4095 : ch * 64 + (ph - (DIV - NAVG));
      2: return (ch * 53 + ph * 97 + 11) % 4096;
      default: return (ph < DIV - NAVG) ? 4095 : 0;
    endcase
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Full readout; outputs checked each cycle at the falling edge.
  task automatic run_readout(input int pass, input bit extra_trig);
    int bad_hold = 0, bad_clk = 0, bad_busy = 0, bad_done = 0, rises = 0;
    int first_bad = -1;
    bit prev_clk = 0;
    for (int c = 0; c < NCH; c++) begin
      int s = 0;
      for (int p = DIV - NAVG; p < DIV; p++) s += pat(pass, c, p);
      expv[c] = s / NAVG;
    end
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int n = 1; n <= TOTAL; n++) begin
      int e_hold, e_clk, e_done, ch, ph;
      e_hold = (n < TOTAL) ? 1 : 0;
      e_done = (n == TOTAL) ? 1 : 0;
      e_clk = 0; ch = 0; ph = 0;
      if (n > DIV && n < TOTAL) begin
        ch = (n - DIV - 1) / DIV;
        ph = (n - DIV - 1) % DIV;
        e_clk = (ph < DIV / 2) ? 1 : 0;
      end
      if (int'(fe_hold) != e_hold) bad_hold++;
      if (int'(fe_clk) != e_clk) bad_clk++;
      if (busy != 1'b1) bad_busy++;
      if (int'(done) != e_done || int'(fe_clr) != e_done) begin
        bad_done++;
        if (first_bad < 0) first_bad = n;
      end
      if (fe_clk && !prev_clk) rises++;
      prev_clk = fe_clk;
      adc = (n > DIV && n < TOTAL) ? 12'(pat(pass, ch, ph)) : 12'hABC;
      trig = (extra_trig && (n == 300 || n == TOTAL - 1)) ? 1'b1 : 1'b0;
      @(negedge clk);
    end
    trig = 1'b0;
    check("R2 hold window mismatching cycles", bad_hold, 0);
    check("R3 fe_clk waveform mismatching cycles", bad_clk, 0);
    check("R3 fe_clk rising edges", rises, NCH);
    check("R8 busy low during readout cycles", bad_busy, 0);
    check("R7 done/clear mismatching cycles", bad_done, 0);
    check("R8 busy after done", int'(busy), 0);
    check("R7 done after done cycle", int'(done), 0);
    if (extra_trig) begin
      for (int k = 0; k < 3 * DIV; k++) begin
        if (busy || fe_hold) bad_busy++;
        @(negedge clk);
      end
      check("R6 no readout after ignored trigger", bad_busy, 0);
    end
  endtask

  task automatic read_back(input string tag);
    int bad = 0, fa = -1, fv = 0;
    for (int a = 0; a < NCH; a++) begin
      rd_addr = 6'(a);
      @(negedge clk);
      if (int'(rd_data) != expv[a]) begin
        bad++;
        if (fa < 0) begin fa = a; fv = int'(rd_data); end
      end
    end
    check({tag, " mismatching entries"}, bad, 0);
    if (fa >= 0) check({tag, " first bad entry"}, fv, expv[fa]);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst_n = 1'b0; trig = 1'b0; adc = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 hold in reset", int'(fe_hold), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 outputs idle after reset",
          int'({fe_hold, fe_clk, fe_clr, busy, done}), 0);

    run_readout(0, 0);
    read_back("R4 full scale no overflow");
    run_readout(1, 1);
    read_back("R4 ramp per channel, R6 extra trigger");
    run_readout(3, 0);
    read_back("R5 early samples ignored");

    // R1: reset in the middle of a readout
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset clears outputs",
          int'({fe_hold, fe_clk, fe_clr, busy, done}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after mid-run reset", int'({fe_hold, busy}), 0);

    run_readout(2, 0);
    read_back("R4 R9 mixed pattern truncation");
    summary();
  end
endmodule